// File: doc/BRIEF.md
# Mismatch-Shaping Unit-Element Select Encoder

This block turns a multi-level quantizer code into a set of single-bit select lines for a bank of equal-weight DAC unit elements. With the default size it accepts a code from 0 to 32 on every clock and drives 32 select lines. The number of lines it asserts always equals the code. Which lines carry the ones is chosen by a binary tree of splitting cells. Each cell divides its share between a lower child and an upper child. When that share is odd, the cell sends the spare unit to whichever child has received fewer spare units so far. This makes the error from static element mismatch first-order high-pass in frequency.

Each node value is carried as a truncated binary word plus one extra bit of unit weight, so no cell contains an adder. Each cell holds a three-state imbalance record in two flip-flops. When a cell is balanced, the dither bit of its tree layer decides where the spare unit goes, and every cell in that layer shares the same dither bit. The tree itself is purely combinational. The select lines are captured in an output register once per clock.

Top module: `mse_encoder`

## Requirements
- R1: With no reset, the select word registered at a clock edge has exactly as many ones as the code value (0 to 2^LAYERS) presented at that edge.
- R2: A synchronous reset drives all select lines to zero and leaves every cell balanced, so that the first odd share after reset follows the dither.
- R3: A cell whose share is even passes half to each child and keeps its imbalance record unchanged.
- R4: A balanced cell with an odd share gives the spare unit to the lower child (lower select indices) when the dither bit of its layer is 1, and to the upper child when it is 0.
- R5: A cell that is not balanced gives an odd share's spare unit to the child that has received fewer units, whatever the dither, and then returns to balanced. The imbalance therefore never leaves -1, 0 or +1.
- R6: dither_in[l] steers every cell of tree layer l, where layer 0 is the root. Select line j is the j-th leaf from the lower end of the tree, so the whole select word follows from the code, the dither bits and the cell history.
- R7: Code 0 gives all select lines low, and the full-scale code 2^LAYERS gives all select lines high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | LAYERS+1 | Quantizer code, 0 to 2^LAYERS |
| dither_in | input | LAYERS | One pseudorandom steering bit per tree layer, bit 0 for the root |
| sel_out | output | 2^LAYERS | Registered unit-element select lines |

## Verification
The hardest state to reach from the ports is an unbalanced cell deep in the tree whose choice overrides the dither. A deep cell only sees an odd share when every cell above it routes a spare unit its way. The bench reaches this state by starting from reset with small codes (1, 2, 3) and all dither bits fixed, which sends spare units down one known path. It then repeats the same code so that the same cells must turn the unit away. Long mixed runs are compared line by line against a behavioural tree model kept in the bench, so imbalance left over from earlier samples is checked across all 31 cells.

// File: rtl/mse_pkg.sv
package mse_pkg;

   // imbalance record of one splitting cell: which child has had one more unit
   typedef enum logic [1:0] {
      IMB_BAL     = 2'b00,
      IMB_A_AHEAD = 2'b01,
      IMB_B_AHEAD = 2'b10
   } imb_t;

   // bit offset of tree layer l inside the flattened word bus;
   // layer j holds 2**j nodes of (layers-j) bits each
   function automatic int hoff(input int l, input int layers);
      int acc;
      acc = 0;
      for (int j = 0; j < l; j++) acc += (2 ** j) * (layers - j);
      return acc;
   endfunction

endpackage

// File: rtl/mse_split_cell.sv
module mse_split_cell
   import mse_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic lsb,     // lowest bit of the truncated binary word
   input  logic ext,     // extra bit of unit weight
   input  logic dith,    // layer dither bit
   output logic ext_a,   // extra bit handed to the lower child
   output logic ext_b    // extra bit handed to the upper child
);

   imb_t imb_q, imb_d;
   logic odd, pair, to_a;

   always_comb begin
      odd   = lsb ^ ext;
      pair  = lsb & ext;
      to_a  = (imb_q == IMB_BAL) ? dith : (imb_q == IMB_B_AHEAD);
      ext_a = pair | (odd & to_a);
      ext_b = pair | (odd & ~to_a);
      imb_d = imb_q;
      if (odd) begin
         if (imb_q == IMB_BAL) imb_d = to_a ? IMB_A_AHEAD : IMB_B_AHEAD;
         else                  imb_d = IMB_BAL;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) imb_q <= IMB_BAL;
      else     imb_q <= imb_d;
   end

   // R3
   even_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(lsb ^ ext) |=> imb_q == $past(imb_q));

   // R4
   bal_follow_chk: assert property (@(posedge clk) disable iff (rst)
      ((lsb ^ ext) && imb_q == IMB_BAL) |=>
         imb_q == ($past(dith) ? IMB_A_AHEAD : IMB_B_AHEAD));

   // R5
   restore_bal_chk: assert property (@(posedge clk) disable iff (rst)
      ((lsb ^ ext) && imb_q != IMB_BAL) |=> imb_q == IMB_BAL);

   // R5
   imb_range_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(imb_q));

endmodule

// File: rtl/mse_tree.sv
module mse_tree
   import mse_pkg::*;
#(
   parameter int LAYERS = 5
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [LAYERS-1:0]    root_h,
   input  logic                 root_e,
   input  logic [LAYERS-1:0]    dith,
   output logic [2**LAYERS-1:0] leaf
);

   localparam int N      = 2 ** LAYERS;
   localparam int ENODES = 2 * N - 1;
   localparam int HBITS  = hoff(LAYERS, LAYERS);

   logic [HBITS-1:0]  hbus;
   logic [ENODES-1:0] ebus;

   assign hbus[LAYERS-1:0] = root_h;
   assign ebus[0]          = root_e;

   for (genvar l = 0; l < LAYERS; l++) begin : g_lay
      localparam int K   = LAYERS - l;
      localparam int OFF = hoff(l, LAYERS);
      localparam int NB  = 2 ** l;
      for (genvar b = 0; b < NB; b++) begin : g_blk
         localparam int NODE = NB - 1 + b;
         localparam int CA   = 2 * NODE + 1;
         localparam int CB   = 2 * NODE + 2;

         mse_split_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .lsb   (hbus[OFF + b*K]),
            .ext   (ebus[NODE]),
            .dith  (dith[l]),
            .ext_a (ebus[CA]),
            .ext_b (ebus[CB])
         );

         if (K > 1) begin : g_pass
            localparam int COFF = hoff(l + 1, LAYERS);
            assign hbus[COFF + (2*b)*(K-1)   +: K-1] = hbus[OFF + b*K + 1 +: K-1];
            assign hbus[COFF + (2*b+1)*(K-1) +: K-1] = hbus[OFF + b*K + 1 +: K-1];
         end
      end
   end

   assign leaf = ebus[ENODES-1:N-1];

endmodule

// File: rtl/mse_encoder.sv
module mse_encoder
   import mse_pkg::*;
#(
   parameter int LAYERS = 5
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [LAYERS:0]      code_in,
   input  logic [LAYERS-1:0]    dither_in,
   output logic [2**LAYERS-1:0] sel_out
);

   localparam int N = 2 ** LAYERS;

   if (LAYERS < 1 || LAYERS > 8) begin : g_bad_size
      $error("mse_encoder: LAYERS must lie in 1..8");
   end

   logic [LAYERS-1:0] root_h;
   logic              root_e;
   logic [N-1:0]      sel_d, sel_q;
   logic              live_q;

   // full scale is folded into an all-ones word plus the extra unit bit
   assign root_e = code_in[LAYERS];
   assign root_h = code_in[LAYERS] ? {LAYERS{1'b1}} : code_in[LAYERS-1:0];

   mse_tree #(.LAYERS(LAYERS)) u_tree (
      .clk    (clk),
      .rst    (rst),
      .root_h (root_h),
      .root_e (root_e),
      .dith   (dither_in),
      .leaf   (sel_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q  <= '0;
         live_q <= 1'b0;
      end else begin
         sel_q  <= sel_d;
         live_q <= 1'b1;
      end
   end

   assign sel_out = sel_q;

   // R1
   code_range_chk: assert property (@(posedge clk) disable iff (rst)
      code_in <= (LAYERS+1)'(N));

   // R1
   ones_match_chk: assert property (@(posedge clk) disable iff (rst)
      live_q |-> $countones(sel_q) == int'($past(code_in)));

   // R2
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> sel_q == '0);

endmodule

// File: tb/mse_encoder_tb.sv
module mse_encoder_tb;

   localparam int L = 5;
   localparam int N = 2 ** L;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [L:0]   code_in = '0;
   logic [L-1:0] dither_in = '0;
   logic [N-1:0] sel_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   int st [0:N-2];   // bench model imbalance: +1 lower child ahead, -1 upper

   always #4 clk = ~clk;   // 125 MHz

   mse_encoder #(.LAYERS(L)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .code_in   (code_in),
      .dither_in (dither_in),
      .sel_out   (sel_out)
   );

   // stimulus {code, dither, expected ones}
   typedef struct packed {
      logic [5:0] code;
      logic [4:0] dth;
      logic [5:0] ones;
   } vec_t;

   localparam vec_t VECS [16] = '{
      '{6'd5,  5'b10110, 6'd5},  '{6'd17, 5'b01011, 6'd17},
      '{6'd31, 5'b11100, 6'd31}, '{6'd1,  5'b00000, 6'd1},
      '{6'd7,  5'b10101, 6'd7},  '{6'd32, 5'b01010, 6'd32},
      '{6'd9,  5'b11111, 6'd9},  '{6'd16, 5'b00110, 6'd16},
      '{6'd3,  5'b10001, 6'd3},  '{6'd11, 5'b01101, 6'd11},
      '{6'd0,  5'b11011, 6'd0},  '{6'd25, 5'b00011, 6'd25},
      '{6'd13, 5'b11000, 6'd13}, '{6'd27, 5'b10010, 6'd27},
      '{6'd15, 5'b00101, 6'd15}, '{6'd21, 5'b01110, 6'd21}
   };

   task automatic model_clear();
      for (int i = 0; i < N - 1; i++) st[i] = 0;
   endtask

   task automatic model_step(input int code, input logic [L-1:0] d,
                             output logic [N-1:0] exp);
      int v [0:2*N-2];
      v[0] = code;
      for (int l = 0; l < L; l++) begin
         for (int b = 0; b < 2 ** l; b++) begin
            int i, half;
            bit go_a;
            i    = 2 ** l - 1 + b;
            half = v[i] / 2;
            if (v[i] % 2 == 1) begin
               go_a = (st[i] == 0) ? d[l] : (st[i] < 0);
               v[2*i+1] = half + (go_a ? 1 : 0);
               v[2*i+2] = half + (go_a ? 0 : 1);
               st[i] += go_a ? 1 : -1;
            end else begin
               v[2*i+1] = half;
               v[2*i+2] = half;
            end
         end
      end
      for (int j = 0; j < N; j++) exp[j] = (v[N-1+j] != 0);
   endtask

   task automatic check_word(input string req, input logic [N-1:0] exp);
      checks++;
      if (sel_out !== exp) begin
         failures++;
         $display("FAIL %s: sel_out actual=%h expected=%h", req, sel_out, exp);
      end
   endtask

   task automatic check_ones(input string req, input int exp);
      checks++;
      if ($countones(sel_out) != exp) begin
         failures++;
         $display("FAIL %s: ones actual=%0d expected=%0d", req, $countones(sel_out), exp);
      end
   endtask

   // drive at a falling edge, check one cycle later at the next falling edge
   task automatic step(input int code, input logic [L-1:0] d, output logic [N-1:0] exp);
      code_in   = (L+1)'(code);
      dither_in = d;
      model_step(code, d, exp);
      @(negedge clk);
   endtask

   task automatic do_reset();
      code_in = '0;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_clear();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] exp;
      @(negedge clk);
      do_reset();
      // R2 reset state
      check_word("R2 reset", '0);

      // R4 balanced root, dither 1 -> lowest line
      step(1, 5'b11111, exp);
      check_word("R4 dither1 lower", 32'h0000_0001);
      // R5 root now lower-ahead: spare goes upper even though dither is 1
      step(1, 5'b11111, exp);
      check_word("R5 override dither", 32'h0001_0000);
      check_word("R5 model", exp);

      // R2 reset clears imbalance; R4 dither 0 -> highest line
      do_reset();
      check_word("R2 reset again", '0);
      step(1, 5'b00000, exp);
      check_word("R4 dither0 upper", 32'h8000_0000);

      // R3 even root splits evenly, root record untouched
      do_reset();
      step(2, 5'b11111, exp);
      check_word("R3 even split", 32'h0001_0001);
      step(2, 5'b11111, exp);
      check_word("R5 layer1 turnaround", 32'h0100_0100);
      step(1, 5'b11111, exp);
      check_word("R3 root still balanced", 32'h0000_0010);
      check_word("R6 model after even", exp);

      // R7 extremes
      step(32, 5'b01010, exp);
      check_word("R7 full scale", {N{1'b1}});
      step(0, 5'b10101, exp);
      check_word("R7 zero", '0);

      // R1 and R6 table walk against the tree model
      foreach (VECS[k]) begin
         step(int'(VECS[k].code), VECS[k].dth, exp);
         check_ones("R1 table", int'(VECS[k].ones));
         check_word("R6 table", exp);
      end

      // R6 long pattern sweep with changing dither per layer
      for (int n = 0; n < 400; n++) begin
         int c;
         logic [L-1:0] dd;
         c  = (n * 7 + n / 5) % (N + 1);
         dd = L'((n * 13) ^ (n >> 2));
         step(c, dd, exp);
         check_ones("R1 sweep", c);
         check_word("R6 sweep", exp);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule